// File: doc/BRIEF.md
# Framebuffer Burst Fetch Controller

This block keeps a display pixel pipeline supplied with framebuffer data held in shared memory. It fills a set of ping-pong line buffers in turn by requesting a shared system bus, issuing fixed-length 8-word (32-byte) burst reads once it holds a grant, and writing the returned words into whichever buffer is being filled. The downstream reader consumes a completed buffer and hands it back with a release pulse.

A 2-bit setting selects how many bursts the fetcher runs per grant, from one to four. Running several bursts per arbitration hides the latency of slow competing transfers on the same bus. The fetcher walks through the frame from a base address over a programmed size in words. A frame need not hold a whole number of buffer fills, so the last buffer of a frame may be only partly filled. That buffer is closed with its true word count, and the next burst starts again at the frame base. A new base or size is taken up only where a frame begins.

Top module: `fb_burst_fetch`

## Requirements
- R1: While reset is held, bus_req, rd_cmd_valid, buf_wr_en, buf_done_valid and frame_start are all 0.
- R2: bus_req rises only when enable is 1 and the buffer next in fill order has not been marked full and not yet released. With every buffer full, bus_req stays 0.
- R3: rd_cmd_valid is asserted only while bus_gnt is 1. Within a frame, each burst address is 32 bytes above the previous one, and every burst address is a multiple of 32 when the base is.
- R4: With bursts-per-grant code c (0 gives 1 burst, 1 gives 2, 2 gives 3, 3 gives 4), the fetcher issues at most c+1 bursts per grant and drops bus_req after the (c+1)th burst unless it stopped earlier under R5.
- R5: When a burst completes a buffer or a frame, bus_req drops after that burst even if the per-grant quota is not used up.
- R6: Returned words are written in arrival order to buf_wr_idx 0, 1, 2 and so on of the buffer being filled. Buffers are filled in order 0, 1, 0, 1, and a word read from byte address A is written as received.
- R7: When a buffer holds BUF_WORDS words, buf_done_valid pulses for one cycle, together with the last word write, carrying that buffer's number and a word count of BUF_WORDS.
- R8: The burst that reaches the end of the frame closes the current buffer with a word count equal to the words written into it (possibly fewer than BUF_WORDS), and frame_start pulses in the same cycle as that buf_done_valid.
- R9: The first burst after frame_start reads from the frame base address.
- R10: A change to cfg_base or cfg_size_words made part-way through a frame does not affect the rest of that frame. It takes effect from the first burst of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new bus requests |
| cfg_base | input | ADDR_W | Frame base byte address, 32-byte aligned |
| cfg_size_words | input | SIZE_W | Frame size in words, a nonzero multiple of 8 |
| cfg_bursts_per_grant | input | QUOTA_W | Bursts per grant minus one |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rd_cmd_valid | output | 1 | One-cycle burst read command |
| rd_addr | output | ADDR_W | Byte address of the burst |
| rd_data_valid | input | 1 | Returned data word valid |
| rd_data | input | DATA_W | Returned data word |
| buf_wr_en | output | 1 | Buffer word write strobe |
| buf_wr_sel | output | $clog2(NBUF) | Buffer being written |
| buf_wr_idx | output | $clog2(BUF_WORDS+1) | Word index inside the buffer |
| buf_wr_data | output | DATA_W | Word written |
| buf_done_valid | output | 1 | Buffer closed and marked full |
| buf_done_sel | output | $clog2(NBUF) | Buffer that was closed |
| buf_done_words | output | $clog2(BUF_WORDS+1) | Valid words in the closed buffer |
| buf_release | input | NBUF | Per-buffer pulse returning a consumed buffer |
| frame_start | output | 1 | Pulse marking the wrap back to the frame base |

## Verification
The assertions assume a well-behaved environment. The arbiter raises bus_gnt only while bus_req is high and holds it until bus_req falls. Memory returns exactly eight data beats per command, and only after the command cycle. The bursts-per-grant code does not change during a tenure, and the base is 32-byte aligned. The bench's arbiter and memory model keep to these rules, and the bench changes configuration only while bus_req is low and no command is on the port. It applies a base and size change while a frame is part-way through, to show that the change is deferred to the next frame. Releases are returned only for buffers the design has reported full.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    localparam int BURST_WORDS = 8;
    localparam int BURST_BYTES = 32;
    localparam int BEAT_W      = $clog2(BURST_WORDS);
    localparam int WORD_SHIFT  = 2;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_CMD,
        FS_DATA
    } fetch_state_e;

endpackage

// File: rtl/fbf_burst_seq.sv
// Bus tenure sequencer: request, command, data beats, quota bookkeeping.
module fbf_burst_seq
    import fbf_pkg::*;
#(
    parameter int QUOTA_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               free_avail,
    input  logic               bus_gnt,
    input  logic               rd_data_valid,
    input  logic [QUOTA_W-1:0] cfg_bpg,
    input  logic               buf_last_word,
    input  logic               frame_last,
    output logic               bus_req,
    output logic               rd_cmd_valid,
    output logic               beat_accept,
    output logic               burst_start,
    output logic               burst_done
);

    typedef struct packed {
        fetch_state_e       st;
        logic [BEAT_W-1:0]  beat;
        logic [QUOTA_W-1:0] nburst;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d       = seq_q;
        beat_accept = 1'b0;
        burst_done  = 1'b0;
        case (seq_q.st)
            FS_IDLE: begin
                if (enable && free_avail) begin
                    seq_d.st = FS_REQ;
                end
            end
            FS_REQ: begin
                if (bus_gnt) begin
                    seq_d.st     = FS_CMD;
                    seq_d.nburst = '0;
                end
            end
            FS_CMD: begin
                seq_d.st   = FS_DATA;
                seq_d.beat = '0;
            end
            FS_DATA: begin
                if (rd_data_valid) begin
                    beat_accept = 1'b1;
                    seq_d.beat  = seq_q.beat + 1'b1;
                    if (seq_q.beat == BEAT_W'(BURST_WORDS - 1)) begin
                        burst_done = 1'b1;
                        if (buf_last_word || frame_last || (seq_q.nburst == cfg_bpg)) begin
                            seq_d.st = FS_IDLE;
                        end else begin
                            seq_d.st     = FS_CMD;
                            seq_d.nburst = seq_q.nburst + 1'b1;
                        end
                    end
                end
            end
            default: seq_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: FS_IDLE, beat: '0, nburst: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_req      = (seq_q.st != FS_IDLE);
    assign rd_cmd_valid = (seq_q.st == FS_CMD);
    assign burst_start  = rd_cmd_valid;

endmodule

// File: rtl/fbf_frame_pos.sv
// Frame walker: shadow base/size latched at frame start, burst address, wrap.
module fbf_frame_pos
    import fbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              burst_start,
    input  logic              burst_done,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              frame_last,
    output logic              frame_start
);

    localparam int CMP_W = SIZE_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [SIZE_W-1:0] pos;
        logic              fstart;
    } pos_t;

    pos_t pos_q, pos_d;
    logic at_boundary;
    logic [ADDR_W-1:0] eff_base;
    logic [CMP_W-1:0]  next_pos;

    assign at_boundary = (pos_q.pos == '0);
    assign eff_base    = at_boundary ? cfg_base : pos_q.base;
    assign cmd_addr    = eff_base + ADDR_W'({pos_q.pos, {WORD_SHIFT{1'b0}}});
    assign next_pos    = {1'b0, pos_q.pos} + CMP_W'(BURST_WORDS);
    assign frame_last  = (next_pos >= {1'b0, pos_q.size});
    assign frame_start = pos_q.fstart;

    always_comb begin
        pos_d        = pos_q;
        pos_d.fstart = 1'b0;
        if (burst_start && at_boundary) begin
            pos_d.base = cfg_base;
            pos_d.size = cfg_size;
        end
        if (burst_done) begin
            if (frame_last) begin
                pos_d.pos    = '0;
                pos_d.fstart = 1'b1;
            end else begin
                pos_d.pos = next_pos[SIZE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '{base: '0, size: '0, pos: '0, fstart: 1'b0};
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/fbf_buf_state.sv
// Ping-pong buffer bookkeeping: full flags, fill order, write port, close event.
module fbf_buf_state #(
    parameter int NBUF      = 2,
    parameter int BUF_WORDS = 320,
    parameter int DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         beat_accept,
    input  logic                         burst_done,
    input  logic                         frame_last,
    input  logic [DATA_W-1:0]            rd_data,
    input  logic [NBUF-1:0]              buf_release,
    output logic                         free_avail,
    output logic                         buf_last_word,
    output logic                         wr_en,
    output logic [$clog2(NBUF)-1:0]      wr_sel,
    output logic [$clog2(BUF_WORDS+1)-1:0] wr_idx,
    output logic [DATA_W-1:0]            wr_data,
    output logic                         done_valid,
    output logic [$clog2(NBUF)-1:0]      done_sel,
    output logic [$clog2(BUF_WORDS+1)-1:0] done_words
);

    localparam int SEL_W = $clog2(NBUF);
    localparam int IDX_W = $clog2(BUF_WORDS + 1);

    typedef struct packed {
        logic [NBUF-1:0]   full;
        logic [SEL_W-1:0]  sel;
        logic [IDX_W-1:0]  ptr;
        logic              wr_en;
        logic [SEL_W-1:0]  wr_sel;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic              done;
        logic [SEL_W-1:0]  done_sel;
        logic [IDX_W-1:0]  done_words;
    } bst_t;

    bst_t bs_q, bs_d;

    assign free_avail    = !bs_q.full[bs_q.sel];
    assign buf_last_word = (bs_q.ptr == IDX_W'(BUF_WORDS - 1));

    always_comb begin
        bs_d         = bs_q;
        bs_d.full    = bs_q.full & ~buf_release;
        bs_d.wr_en   = beat_accept;
        bs_d.wr_sel  = bs_q.sel;
        bs_d.wr_idx  = bs_q.ptr;
        bs_d.wr_data = rd_data;
        bs_d.done    = 1'b0;
        if (beat_accept) begin
            bs_d.ptr = bs_q.ptr + 1'b1;
        end
        if (burst_done && (buf_last_word || frame_last)) begin
            bs_d.full[bs_q.sel] = 1'b1;
            bs_d.done           = 1'b1;
            bs_d.done_sel       = bs_q.sel;
            bs_d.done_words     = bs_q.ptr + 1'b1;
            bs_d.ptr            = '0;
            bs_d.sel            = (bs_q.sel == SEL_W'(NBUF - 1)) ? '0 : bs_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign wr_en      = bs_q.wr_en;
    assign wr_sel     = bs_q.wr_sel;
    assign wr_idx     = bs_q.wr_idx;
    assign wr_data    = bs_q.wr_data;
    assign done_valid = bs_q.done;
    assign done_sel   = bs_q.done_sel;
    assign done_words = bs_q.done_words;

endmodule

// File: rtl/fb_burst_fetch.sv
// Framebuffer burst fetcher top: ties sequencer, frame walker and buffer state.
module fb_burst_fetch #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 20,
    parameter int BUF_WORDS = 320,
    parameter int NBUF      = 2,
    parameter int QUOTA_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [ADDR_W-1:0]              cfg_base,
    input  logic [SIZE_W-1:0]              cfg_size_words,
    input  logic [QUOTA_W-1:0]             cfg_bursts_per_grant,
    output logic                           bus_req,
    input  logic                           bus_gnt,
    output logic                           rd_cmd_valid,
    output logic [ADDR_W-1:0]              rd_addr,
    input  logic                           rd_data_valid,
    input  logic [DATA_W-1:0]              rd_data,
    output logic                           buf_wr_en,
    output logic [$clog2(NBUF)-1:0]        buf_wr_sel,
    output logic [$clog2(BUF_WORDS+1)-1:0] buf_wr_idx,
    output logic [DATA_W-1:0]              buf_wr_data,
    output logic                           buf_done_valid,
    output logic [$clog2(NBUF)-1:0]        buf_done_sel,
    output logic [$clog2(BUF_WORDS+1)-1:0] buf_done_words,
    input  logic [NBUF-1:0]                buf_release,
    output logic                           frame_start
);

    logic free_avail;
    logic buf_last_word;
    logic frame_last;
    logic beat_accept;
    logic burst_start;
    logic burst_done;

    fbf_burst_seq #(
        .QUOTA_W(QUOTA_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .free_avail   (free_avail),
        .bus_gnt      (bus_gnt),
        .rd_data_valid(rd_data_valid),
        .cfg_bpg      (cfg_bursts_per_grant),
        .buf_last_word(buf_last_word),
        .frame_last   (frame_last),
        .bus_req      (bus_req),
        .rd_cmd_valid (rd_cmd_valid),
        .beat_accept  (beat_accept),
        .burst_start  (burst_start),
        .burst_done   (burst_done)
    );

    fbf_frame_pos #(
        .ADDR_W(ADDR_W),
        .SIZE_W(SIZE_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size_words),
        .burst_start(burst_start),
        .burst_done (burst_done),
        .cmd_addr   (rd_addr),
        .frame_last (frame_last),
        .frame_start(frame_start)
    );

    fbf_buf_state #(
        .NBUF     (NBUF),
        .BUF_WORDS(BUF_WORDS),
        .DATA_W   (DATA_W)
    ) u_bufs (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_accept  (beat_accept),
        .burst_done   (burst_done),
        .frame_last   (frame_last),
        .rd_data      (rd_data),
        .buf_release  (buf_release),
        .free_avail   (free_avail),
        .buf_last_word(buf_last_word),
        .wr_en        (buf_wr_en),
        .wr_sel       (buf_wr_sel),
        .wr_idx       (buf_wr_idx),
        .wr_data      (buf_wr_data),
        .done_valid   (buf_done_valid),
        .done_sel     (buf_done_sel),
        .done_words   (buf_done_words)
    );

endmodule

// File: rtl/fb_burst_fetch_chk.sv
// Property checker bound to the fetcher top.
module fb_burst_fetch_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUF_WORDS = 320,
    parameter int QUOTA_W   = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_req,
    input logic                           bus_gnt,
    input logic                           rd_cmd_valid,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [QUOTA_W-1:0]             cfg_bursts_per_grant,
    input logic                           free_avail,
    input logic                           buf_done_valid,
    input logic [$clog2(BUF_WORDS+1)-1:0] buf_done_words,
    input logic                           frame_start
);

    logic [QUOTA_W:0] tenure_cmds_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tenure_cmds_q <= '0;
        end else if (!bus_req) begin
            tenure_cmds_q <= '0;
        end else if (rd_cmd_valid) begin
            tenure_cmds_q <= tenure_cmds_q + 1'b1;
        end
    end

    p_cmd_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid |-> (bus_gnt && bus_req));

    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid |-> (rd_addr[4:0] == 5'd0));

    p_req_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(free_avail));

    p_quota_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid |-> (tenure_cmds_q <= {1'b0, cfg_bursts_per_grant}));

    p_done_words_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done_valid |-> ((buf_done_words != '0) &&
                            (int'(buf_done_words) <= BUF_WORDS) &&
                            ((buf_done_words % 8) == 0)));

    p_frame_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> buf_done_valid);

endmodule

bind fb_burst_fetch fb_burst_fetch_chk #(
    .ADDR_W   (ADDR_W),
    .BUF_WORDS(BUF_WORDS),
    .QUOTA_W  (QUOTA_W)
) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .bus_req             (bus_req),
    .bus_gnt             (bus_gnt),
    .rd_cmd_valid        (rd_cmd_valid),
    .rd_addr             (rd_addr),
    .cfg_bursts_per_grant(cfg_bursts_per_grant),
    .free_avail          (free_avail),
    .buf_done_valid      (buf_done_valid),
    .buf_done_words      (buf_done_words),
    .frame_start         (frame_start)
);

// File: tb/fb_burst_fetch_test.sv
module fb_burst_fetch_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int SW   = 20;
    localparam int BUF  = 32;
    localparam int NB   = 2;
    localparam int QW   = 2;
    localparam int IW   = $clog2(BUF + 1);
    localparam int WDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [AW-1:0] cfg_base = 32'h0000_1000;
    logic [SW-1:0] cfg_size_words = 20'd80;
    logic [QW-1:0] cfg_bursts_per_grant = 2'd0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          rd_cmd_valid;
    logic [AW-1:0] rd_addr;
    logic          rd_data_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          buf_wr_en;
    logic [0:0]    buf_wr_sel;
    logic [IW-1:0] buf_wr_idx;
    logic [DW-1:0] buf_wr_data;
    logic          buf_done_valid;
    logic [0:0]    buf_done_sel;
    logic [IW-1:0] buf_done_words;
    logic [NB-1:0] buf_release = '0;
    logic          frame_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_burst_fetch #(
        .ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW),
        .BUF_WORDS(BUF), .NBUF(NB), .QUOTA_W(QW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_base(cfg_base), .cfg_size_words(cfg_size_words),
        .cfg_bursts_per_grant(cfg_bursts_per_grant),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .rd_cmd_valid(rd_cmd_valid), .rd_addr(rd_addr),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_sel(buf_wr_sel),
        .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
        .buf_done_valid(buf_done_valid), .buf_done_sel(buf_done_sel),
        .buf_done_words(buf_done_words), .buf_release(buf_release),
        .frame_start(frame_start)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard of expected buffer-close events
    int exp_sel[$];
    int exp_words[$];
    bit exp_fs[$];

    task automatic push_done(input int sel, input int words, input bit fs);
        exp_sel.push_back(sel);
        exp_words.push_back(words);
        exp_fs.push_back(fs);
    endtask

    // reference model state
    logic [AW-1:0] m_base = '0;
    int  m_size = 0;
    int  m_pos = 0;
    int  m_bufidx = 0;
    int  m_sel = 0;
    bit [NB-1:0] m_full = '0;
    int  tenure_cnt = 0;
    bit  tenure_end_buf = 1'b0;
    bit  req_prev = 1'b0;
    bit  midframe = 1'b0;
    int  frames_seen = 0;
    bit  hold = 1'b0;
    bit  stall_req_seen = 1'b0;
    int  cycle = 0;
    int  rel_timer [NB];
    bit  pend_valid = 1'b0;
    logic [AW-1:0] pend_base = '0;
    logic [SW-1:0] pend_size = '0;
    logic [QW-1:0] pend_bpg = '0;
    bit  mem_active = 1'b0;
    int  mem_wait = 0;
    int  mem_beat = 0;
    logic [AW-1:0] mem_addr = '0;
    int  arb_wait = 0;

    initial begin
        for (int b = 0; b < NB; b++) rel_timer[b] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int sel_now;
            string lab;
            cycle++;
            // word writes (R6) and burst-end bookkeeping
            if (buf_wr_en) begin
                chk(buf_wr_sel == 1'(m_sel), "R6", "write buffer", buf_wr_sel, m_sel);
                chk(int'(buf_wr_idx) == m_bufidx, "R6", "write index", buf_wr_idx, m_bufidx);
                chk(buf_wr_data == m_base + AW'(m_pos * 4), "R6", "write data",
                    buf_wr_data, m_base + AW'(m_pos * 4));
                m_pos++;
                m_bufidx++;
                if ((m_bufidx % 8) == 0) begin
                    if (m_pos >= m_size) begin
                        push_done(m_sel, m_bufidx, 1'b1);
                        m_pos = 0; m_bufidx = 0; m_sel ^= 1;
                        tenure_end_buf = 1'b1; midframe = 1'b0;
                    end else if (m_bufidx == BUF) begin
                        push_done(m_sel, BUF, 1'b0);
                        m_bufidx = 0; m_sel ^= 1;
                        tenure_end_buf = 1'b1;
                    end
                end
            end
            // buffer-close monitor (R7, R8)
            if (buf_done_valid) begin
                if (exp_sel.size() == 0) begin
                    chk(1'b0, "R7", "unexpected close", 1, 0);
                end else begin
                    int es, ew;
                    bit ef;
                    es = exp_sel.pop_front();
                    ew = exp_words.pop_front();
                    ef = exp_fs.pop_front();
                    lab = ef ? "R8" : "R7";
                    chk(buf_done_sel == 1'(es), lab, "closed buffer", buf_done_sel, es);
                    chk(int'(buf_done_words) == ew, lab, "word count", buf_done_words, ew);
                    chk(frame_start == ef, "R8", "frame_start with close", frame_start, ef);
                end
                sel_now = int'(buf_done_sel);
                m_full[sel_now] = 1'b1;
                rel_timer[sel_now] = 12;
                if (frame_start) frames_seen++;
            end else if (frame_start) begin
                chk(1'b0, "R8", "frame_start without close", 1, 0);
            end
            // burst commands (R3, R9, R10)
            if (rd_cmd_valid) begin
                logic [AW-1:0] ea;
                chk(bus_gnt == 1'b1, "R3", "command without grant", bus_gnt, 1);
                if (m_pos == 0) begin
                    m_base = cfg_base;
                    m_size = int'(cfg_size_words);
                end
                ea = m_base + AW'(m_pos * 4);
                lab = (m_pos == 0) ? "R9" : (midframe ? "R10" : "R3");
                chk(rd_addr == ea, lab, "burst address", rd_addr, ea);
                tenure_cnt++;
                mem_active = 1'b1;
                mem_wait = (cycle % 2) + 1;
                mem_beat = 0;
                mem_addr = rd_addr;
            end
            // request edges (R2, R4, R5)
            if (bus_req && !req_prev) begin
                chk(!m_full[m_sel], "R2", "request with next buffer full", m_full[m_sel], 0);
                if (hold && (&m_full)) stall_req_seen = 1'b1;
                tenure_cnt = 0;
                tenure_end_buf = 1'b0;
            end
            if (!bus_req && req_prev) begin
                int q;
                q = int'(cfg_bursts_per_grant) + 1;
                lab = (tenure_end_buf && tenure_cnt < q) ? "R5" : "R4";
                chk((tenure_cnt <= q) && (tenure_cnt == q || tenure_end_buf), lab,
                    "bursts in tenure", tenure_cnt, q);
            end
            req_prev = bus_req;

            // drive inputs for the next edge: arbiter
            if (!bus_req) begin
                bus_gnt = 1'b0;
                arb_wait = cycle % 4;
            end else if (!bus_gnt) begin
                if (arb_wait == 0) bus_gnt = 1'b1;
                else arb_wait--;
            end
            // memory model
            rd_data_valid = 1'b0;
            if (mem_active) begin
                if (mem_wait > 0) begin
                    mem_wait--;
                end else begin
                    rd_data_valid = 1'b1;
                    rd_data = mem_addr + DW'(mem_beat * 4);
                    mem_beat++;
                    if (mem_beat == 8) mem_active = 1'b0;
                end
            end
            // reader
            buf_release = '0;
            for (int b = 0; b < NB; b++) begin
                if (rel_timer[b] > 1) begin
                    rel_timer[b]--;
                end else if (rel_timer[b] == 1 && !hold) begin
                    buf_release[b] = 1'b1;
                    m_full[b] = 1'b0;
                    rel_timer[b] = 0;
                end
            end
            // configuration updates only while idle
            if (pend_valid && !bus_req && !rd_cmd_valid) begin
                if (m_pos != 0 && (pend_base != cfg_base || int'(pend_size) != m_size))
                    midframe = 1'b1;
                cfg_base = pend_base;
                cfg_size_words = pend_size;
                cfg_bursts_per_grant = pend_bpg;
                pend_valid = 1'b0;
            end
        end
    end

    task automatic set_cfg(input logic [AW-1:0] b, input logic [SW-1:0] s, input logic [QW-1:0] q);
        @(negedge clk);
        pend_base = b; pend_size = s; pend_bpg = q;
        pend_valid = 1'b1;
        wait (!pend_valid);
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames_seen + n;
        wait (frames_seen >= target);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, even with enable high
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R1", "bus_req in reset", bus_req, 0);
        chk(rd_cmd_valid == 1'b0, "R1", "command in reset", rd_cmd_valid, 0);
        chk(buf_wr_en == 1'b0, "R1", "write in reset", buf_wr_en, 0);
        chk(buf_done_valid == 1'b0, "R1", "close in reset", buf_done_valid, 0);
        chk(frame_start == 1'b0, "R1", "frame_start in reset", frame_start, 0);
        enable = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: no request while disabled
        repeat (10) @(negedge clk);
        chk(bus_req == 1'b0, "R2", "request while disabled", bus_req, 0);
        enable = 1'b1;
        // one burst per grant, frame 80 words: 32 + 32 + 16 partial
        wait_frames(2);
        // three bursts per grant: buffer end cuts the second tenure short (R5)
        set_cfg(32'h0000_2000, 20'd96, 2'd2);
        wait_frames(3);
        // four per grant, frame 40 words: 32 + 8 partial
        set_cfg(32'h0000_3000, 20'd40, 2'd3);
        wait_frames(3);
        // R10: change base and size part-way through a frame
        wait (m_pos > 0);
        set_cfg(32'h0000_8000, 20'd64, 2'd3);
        wait_frames(3);
        // R2: both buffers held full by the reader
        hold = 1'b1;
        wait (&m_full);
        repeat (30) @(negedge clk);
        chk(stall_req_seen == 1'b0 && bus_req == 1'b0, "R2", "request with all buffers full",
            bus_req, 0);
        hold = 1'b0;
        wait_frames(2);
        @(negedge clk);
        chk(exp_sel.size() == 0, "R7", "pending closes at end", exp_sel.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule